// File: doc/BRIEF.md
# Serial User Flash Interface

This block pairs a small on-chip user flash array, reachable only through a serial address register and a serial data register, with a parallel request front end. A caller presents an operation code, a word address and a write word, pulses start, and waits for a one-cycle done. The front end turns each request into the serial sequence the array expects: it shifts address bits, issues read strobes, shifts data words in or out, and holds program or erase requests.

The array is a behavioural register model. It runs its own program and erase timing, and a busy flag shows when that timing is in progress. Program and erase latencies are parameters. Consecutive words can be fetched without resending an address. To do this the address register is clocked with shifting disabled, which advances it by one.

Top module: `sfi_top`

## Requirements
- R1: Operation code 2'b00 is a standard read. The 9-bit address is shifted into the array MSB first. The 16-bit word stored there is then shifted out MSB first and appears on `rdata` when `done` pulses.
- R2: The array holds 512 words of 16 bits, and every address from 0 to 511 can be selected and returns its own word.
- R3: Operation code 2'b01 is a stream read. It sends no address. It returns the word at the address of the previous access plus one.
- R4: A stream read issued when the stored address is 511 returns the word at address 0.
- R5: Operation code 2'b10 programs a word. The stored value becomes the old value bitwise AND the write data, so programming can only clear bits.
- R6: Operation code 2'b11 erases the whole array. Afterwards every word reads 16'hFFFF.
- R7: `flash_busy` rises in the cycle after a program or erase request reaches the array. It stays high for exactly `PROG_LAT` cycles for a program and `ERASE_LAT` cycles for an erase.
- R8: A program or erase request stays asserted to the array until `flash_busy` has fallen.
- R9: Every accepted operation ends with `done` high for exactly one cycle.
- R10: A start pulse that arrives while an operation is in progress is ignored. It causes no extra `done` and no change to the array or to the result.
- R11: After reset, `done` and `flash_busy` are low, `rdata` is zero, and every array word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the front end is idle |
| op | input | 2 | Operation code: 00 read, 01 stream read, 10 program, 11 erase |
| addr | input | 9 | Word address for read and program |
| wdata | input | 16 | Data word for program |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-cycle completion pulse |
| flash_busy | output | 1 | Array internal program or erase in progress |

## Verification
The hardest case to reach is the address wrap during a stream read. No request can set the stored address directly; it only gets to 511 through an earlier access. The stimulus therefore does a standard read near the top of the address space and then chains stream reads across the boundary. A second hard case is a start pulse that arrives in the middle of a running read and carries an erase code. It is checked by reading the programmed words afterwards: none of them may have been erased.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 16;
    localparam int WORDS  = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ERASED_WORD = '1;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_STREAM = 2'b01,
        OP_PROG   = 2'b10,
        OP_ERASE  = 2'b11
    } sfi_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INC,
        ST_RDSTB,
        ST_DSHIFT,
        ST_DLOAD,
        ST_HOLD,
        ST_DONE
    } sfi_state_e;

    typedef struct packed {
        logic aclk;
        logic ashift;
        logic adin;
        logic dclk;
        logic dshift;
        logic ddin;
        logic rd;
        logic prog;
        logic erase;
    } sfi_ser_t;

    function automatic sfi_state_e first_state(sfi_op_e o);
        case (o)
            OP_STREAM: return ST_INC;
            OP_ERASE:  return ST_HOLD;
            default:   return ST_ADDR;
        endcase
    endfunction
endpackage

// File: rtl/sfi_addr_reg.sv
module sfi_addr_reg #(
    parameter int AW = sfi_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_clk,
    input  logic          shift_en,
    input  logic          shift_din,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] TOP_ADDR = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (shift_clk) begin
            if (shift_en) addr <= {addr[AW-2:0], shift_din};
            else          addr <= addr + 1'b1;
        end
    end

    assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_clk && !shift_en && addr == TOP_ADDR) |=> (addr == '0));
endmodule

// File: rtl/sfi_flash_core.sv
module sfi_flash_core #(
    parameter int AW        = sfi_pkg::ADDR_W,
    parameter int DW        = sfi_pkg::DATA_W,
    parameter int PROG_LAT  = 4,
    parameter int ERASE_LAT = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          dclk,
    input  logic          dshift,
    input  logic          ddin,
    input  logic          rd,
    input  logic          prog,
    input  logic          erase,
    output logic          ddout,
    output logic          busy
);
    localparam int NWORDS  = 1 << AW;
    localparam int MAX_LAT = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);
    localparam logic [DW-1:0] ALL_ONES = '1;

    logic [DW-1:0]    cells [NWORDS];
    logic [DW-1:0]    dreg;
    logic [DW-1:0]    op_data;
    logic [AW-1:0]    op_addr;
    logic [LAT_W-1:0] cnt;
    logic             req_seen;
    logic             is_erase;
    logic             req_any;
    logic             finish;

    assign req_any = prog || erase;
    assign finish  = busy && req_any && (cnt == '0);
    assign ddout   = dreg[DW-1];

    // data shift register
    always_ff @(posedge clk) begin
        if (rst)                  dreg <= '0;
        else if (rd)              dreg <= cells[addr];
        else if (dclk && dshift)  dreg <= {dreg[DW-2:0], ddin};
    end

    // internal program / erase timer
    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            req_seen <= 1'b0;
            is_erase <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            if (!req_any) req_seen <= 1'b0;
            if (!busy) begin
                if (req_any && !req_seen) begin
                    busy     <= 1'b1;
                    req_seen <= 1'b1;
                    is_erase <= erase;
                    cnt      <= erase ? LAT_W'(ERASE_LAT - 1) : LAT_W'(PROG_LAT - 1);
                    op_addr  <= addr;
                    op_data  <= dreg;
                end
            end else if (!req_any) begin
                busy <= 1'b0;
            end else if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // cell array
    always_ff @(posedge clk) begin
        if (rst || (finish && is_erase)) begin
            for (int i = 0; i < NWORDS; i++) cells[i] <= ALL_ONES;
        end else if (finish) begin
            cells[op_addr] <= cells[op_addr] & op_data;
        end
    end

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (req_any && !busy && !req_seen) |=> busy);

    assert_no_read_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd);
endmodule

// File: rtl/sfi_ctrl.sv
module sfi_ctrl
    import sfi_pkg::*;
#(
    parameter int AW = sfi_pkg::ADDR_W,
    parameter int DW = sfi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  sfi_op_e       op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          ddout,
    output sfi_ser_t      ser,
    output logic [DW-1:0] rdata,
    output logic          done
);
    localparam int CNT_W = $clog2(DW);

    sfi_state_e    state;
    sfi_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [CNT_W-1:0] bit_cnt;
    logic          seen_busy;

    always_comb begin
        ser  = '0;
        done = 1'b0;
        case (state)
            ST_ADDR: begin
                ser.aclk   = 1'b1;
                ser.ashift = 1'b1;
                ser.adin   = addr_q[AW-1];
            end
            ST_INC:    ser.aclk = 1'b1;
            ST_RDSTB:  ser.rd   = 1'b1;
            ST_DSHIFT: begin
                ser.dclk   = 1'b1;
                ser.dshift = 1'b1;
            end
            ST_DLOAD: begin
                ser.dclk   = 1'b1;
                ser.dshift = 1'b1;
                ser.ddin   = wdata_q[DW-1];
            end
            ST_HOLD: begin
                ser.prog  = (op_q == OP_PROG);
                ser.erase = (op_q == OP_ERASE);
            end
            ST_DONE:   done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_READ;
            addr_q    <= '0;
            wdata_q   <= '0;
            bit_cnt   <= '0;
            seen_busy <= 1'b0;
            rdata     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q      <= op;
                    addr_q    <= addr;
                    wdata_q   <= wdata;
                    bit_cnt   <= '0;
                    seen_busy <= 1'b0;
                    state     <= first_state(op);
                end
                ST_ADDR: begin
                    addr_q <= addr_q << 1;
                    if (bit_cnt == CNT_W'(AW - 1)) begin
                        bit_cnt <= '0;
                        state   <= (op_q == OP_PROG) ? ST_DLOAD : ST_RDSTB;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_INC:   state <= ST_RDSTB;
                ST_RDSTB: begin
                    bit_cnt <= '0;
                    state   <= ST_DSHIFT;
                end
                ST_DSHIFT: begin
                    rdata <= {rdata[DW-2:0], ddout};
                    if (bit_cnt == CNT_W'(DW - 1)) state <= ST_DONE;
                    else bit_cnt <= bit_cnt + 1'b1;
                end
                ST_DLOAD: begin
                    wdata_q <= wdata_q << 1;
                    if (bit_cnt == CNT_W'(DW - 1)) state <= ST_HOLD;
                    else bit_cnt <= bit_cnt + 1'b1;
                end
                ST_HOLD: begin
                    if (busy) seen_busy <= 1'b1;
                    if (seen_busy && !busy) state <= ST_DONE;
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assert_hold_until_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ser.prog || ser.erase) |-> !busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> (op_q == $past(op_q) && rdata == $past(rdata)) || state == ST_DSHIFT || $past(state) == ST_DSHIFT);

    assert_strobe_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ser.rd, ser.prog, ser.erase, ser.aclk, ser.dclk}));
endmodule

// File: rtl/sfi_top.sv
module sfi_top #(
    parameter int PROG_LAT  = 4,
    parameter int ERASE_LAT = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [8:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        done,
    output logic        flash_busy
);
    import sfi_pkg::*;

    sfi_ser_t          ser;
    logic [ADDR_W-1:0] cur_addr;
    logic              ddout;

    sfi_ctrl #(.AW(ADDR_W), .DW(DATA_W)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (sfi_op_e'(op)),
        .addr  (addr),
        .wdata (wdata),
        .busy  (flash_busy),
        .ddout (ddout),
        .ser   (ser),
        .rdata (rdata),
        .done  (done)
    );

    sfi_addr_reg #(.AW(ADDR_W)) i_addr (
        .clk       (clk),
        .rst       (rst),
        .shift_clk (ser.aclk),
        .shift_en  (ser.ashift),
        .shift_din (ser.adin),
        .addr      (cur_addr)
    );

    sfi_flash_core #(
        .AW(ADDR_W), .DW(DATA_W), .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
    ) i_core (
        .clk    (clk),
        .rst    (rst),
        .addr   (cur_addr),
        .dclk   (ser.dclk),
        .dshift (ser.dshift),
        .ddin   (ser.ddin),
        .rd     (ser.rd),
        .prog   (ser.prog),
        .erase  (ser.erase),
        .ddout  (ddout),
        .busy   (flash_busy)
    );
endmodule

// File: tb/test_sfi_top.sv
module test_sfi_top;
    localparam int P_LAT = 4;
    localparam int E_LAT = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done;
    logic        flash_busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;
    logic [15:0] model [512];
    logic [8:0]  mptr = '0;

    always #2 clk = ~clk;

    sfi_top #(.PROG_LAT(P_LAT), .ERASE_LAT(E_LAT)) i_sfi_top (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .flash_busy(flash_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 40503 + 4660 * k) ^ (a << 7) ^ (k * 257));
    endfunction

    task automatic do_op(input logic [1:0] o, input logic [8:0] a, input logic [15:0] d,
                         input bit inject, output int busy_cyc);
        int done_cyc = 0;
        int n = 0;
        busy_cyc = 0;
        @(negedge clk);
        start = 1'b1; op = o; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        while (done_cyc == 0 && !timed_out) begin
            if (inject && n == 4) begin start = 1'b1; op = 2'b11; end
            if (inject && n == 5) start = 1'b0;
            if (flash_busy) busy_cyc++;
            if (done) done_cyc++;
            if (done_cyc == 0) @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
        if (flash_busy) busy_cyc++;
        case (o)
            2'b00: mptr = a;
            2'b01: mptr = mptr + 9'd1;
            2'b10: begin mptr = a; model[a] = model[a] & d; end
            default: for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;
        endcase
    endtask

    task automatic rd_std(input logic [8:0] a, input string tag);
        int b;
        do_op(2'b00, a, 16'h0, 1'b0, b);
        check(rdata == model[a], tag, rdata, model[a]);
    endtask

    task automatic rd_stream(input string tag);
        int b;
        logic [8:0] nxt = mptr + 9'd1;
        do_op(2'b01, 9'd0, 16'h0, 1'b0, b);
        check(rdata == model[nxt], tag, rdata, model[nxt]);
    endtask

    initial begin
        int b;
        for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R11 done after reset", done, 0);
        check(flash_busy == 1'b0, "R11 busy after reset", flash_busy, 0);
        check(rdata == 16'h0, "R11 rdata after reset", rdata, 0);
        rd_std(9'd0, "R11 erased word 0");
        rd_std(9'd511, "R11 erased word 511");
        rd_std(9'd170, "R11 erased word 170");

        // program every word, checking the program busy length (R5, R7)
        for (int a = 0; a < 512; a++) begin
            do_op(2'b10, 9'(a), pat(a, 1), 1'b0, b);
            check(b == P_LAT, "R7 program busy length", b, P_LAT);
        end
        // read every word back (R1, R2)
        for (int a = 0; a < 512; a++) rd_std(9'(a), "R1 R2 standard read");

        // stream reads across the top of the array (R3, R4)
        rd_std(9'd507, "R1 read before stream");
        for (int k = 0; k < 7; k++) rd_stream("R3 R4 stream read");
        rd_std(9'd100, "R1 read before stream");
        for (int k = 0; k < 3; k++) rd_stream("R3 stream read");

        // second program only clears bits (R5)
        for (int a = 0; a < 32; a++) begin
            do_op(2'b10, 9'(a * 13), pat(a, 5) | 16'h8001, 1'b0, b);
            rd_std(9'(a * 13), "R5 program AND");
        end

        // start during a read is ignored (R10)
        do_op(2'b00, 9'd77, 16'h0, 1'b1, b);
        check(rdata == model[77], "R10 result unchanged", rdata, model[77]);
        check(b == 0, "R10 no erase started", b, 0);
        for (int a = 0; a < 512; a += 37) rd_std(9'(a), "R10 array intact");

        // erase (R6, R7)
        do_op(2'b11, 9'd0, 16'h0, 1'b0, b);
        check(b == E_LAT, "R7 erase busy length", b, E_LAT);
        for (int a = 0; a < 512; a++) rd_std(9'(a), "R6 erased read");
        rd_stream("R4 stream after erase");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule